// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. It spends one clock cycle per multiplier bit. The only adder it uses is `WIDTH` bits wide. That adder adds the multiplicand into the upper half of a double-width accumulator. The whole accumulator, with the adder's carry-out as the new top bit, then moves one place to the right. After the last multiplier bit has been used, the accumulator holds the exact product.

A client drives the operands and raises `start` for one cycle while the block is idle. `busy` then stays high while the block computes. A single-cycle `done` pulse marks the cycle in which `product` and `overflow` show the new result. The result holds its value until the next operation finishes. A client may raise `start` again in the same cycle that `done` is high.

Top module: `seq_shiftadd_mul`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `busy`, `done`, `overflow` and every bit of `product` are 0.
- R2: The operands are captured on the clock edge at which an idle block samples `start` high. Changes to `multiplicand` or `multiplier` after that edge have no effect on the result.
- R3: If `start` is accepted at edge k, `busy` is high after edges k through k+WIDTH-1 and low after edge k+WIDTH. `done` is high after edge k+WIDTH.
- R4: `done` is high for exactly one cycle per operation and is never high together with `busy`.
- R5: When `done` is high, `product` equals the unsigned product multiplicand × multiplier, all `2*WIDTH` bits, including both operands zero and both operands all-ones. For example, at WIDTH 4, 0110 × 1010 gives 0011_1100.
- R6: When `done` is high, `overflow` is 1 exactly when bits [2*WIDTH-1:WIDTH] of `product` are not all zero.
- R7: A `start` pulse while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R8: `product` and `overflow` keep their values in every cycle in which `done` is low.
- R9: A `start` sampled in the cycle in which `done` is high begins a new operation with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiplication; takes effect only when idle |
| multiplicand | input | WIDTH | Unsigned multiplicand, captured on accepted start |
| multiplier | input | WIDTH | Unsigned multiplier, captured on accepted start |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle pulse when a new result is presented |
| product | output | 2*WIDTH | Full unsigned product, held until the next completion |
| overflow | output | 1 | High when the upper half of the product is non-zero |

## Verification
Every multiplicand is paired with a set of multipliers: zero, one, single-bit powers of two, the alternating patterns and all-ones. These pairs separate a correct add-select from one that inspects the wrong multiplier bit. They also expose a carry that is lost during the rotate, because only large operands produce a carry out of the upper-half add. Random operand pairs then come in back-to-back, which tests the handover in the `done` cycle. While an operation runs, the bench scrambles the operand inputs and sends stray `start` pulses, so any late capture or restart changes the result or the timing. The textbook case 6 × 10 and the all-ones square check that the overflow flag agrees with the upper half.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

  // Control strobes passed from sequencer to datapath each cycle
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // perform one add-and-rotate iteration
    logic last;   // this step is the final iteration
  } mulStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mulState_t;

endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output mulStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = $clog2(WIDTH + 1);

  mulState_t        stateQ;
  logic [CNT_W-1:0] cntQ;
  logic             doneQ;
  logic             lastIter;

  assign lastIter = (cntQ == CNT_W'(1));

  always_comb begin
    strobe      = '0;
    strobe.load = (stateQ == ST_IDLE) && start;
    strobe.step = (stateQ == ST_RUN);
    strobe.last = (stateQ == ST_RUN) && lastIter;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ <= ST_RUN;
            cntQ   <= CNT_W'(WIDTH);
          end
        end
        ST_RUN: begin
          cntQ <= cntQ - CNT_W'(1);
          if (lastIter) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateQ == ST_RUN);
  assign done = doneQ;

endmodule

// File: rtl/seq_mul_datapath.sv
module seq_mul_datapath
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulStrobe_t         strobe,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product,
  output logic               overflow
);

  localparam int ACC_W = 2 * WIDTH;

  logic [WIDTH-1:0] mcandQ;
  logic [WIDTH-1:0] mplierQ;
  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] productQ;
  logic             overflowQ;

  logic             addSel;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   upperSum;
  logic [ACC_W-1:0] accNext;

  // Single-width add into the upper half; carry-out kept in upperSum[WIDTH]
  assign addSel   = mplierQ[0];
  assign addend   = addSel ? mcandQ : '0;
  assign upperSum = {1'b0, accQ[ACC_W-1:WIDTH]} + {1'b0, addend};

  // Rotate right through the carry: carry lands in the top bit
  generate
    if (WIDTH > 1) begin : g_rotWide
      assign accNext = {upperSum[WIDTH], upperSum[WIDTH-1:0], accQ[WIDTH-1:1]};
    end else begin : g_rotNarrow
      assign accNext = {upperSum[WIDTH], upperSum[WIDTH-1:0]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandQ  <= '0;
      mplierQ <= '0;
      accQ    <= '0;
    end else if (strobe.load) begin
      mcandQ  <= multiplicand;
      mplierQ <= multiplier;
      accQ    <= '0;
    end else if (strobe.step) begin
      mplierQ <= mplierQ >> 1;
      accQ    <= accNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      productQ  <= '0;
      overflowQ <= 1'b0;
    end else if (strobe.step && strobe.last) begin
      productQ  <= accNext;
      overflowQ <= |accNext[ACC_W-1:WIDTH];
    end
  end

  assign product  = productQ;
  assign overflow = overflowQ;

endmodule

// File: rtl/seq_shiftadd_mul.sv
module seq_shiftadd_mul
  import seq_mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product,
  output logic               overflow
);

  mulStrobe_t strobe;

  seq_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  seq_mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product),
    .overflow     (overflow)
  );

endmodule

// File: rtl/seq_shiftadd_mul_checker.sv
module seq_shiftadd_mul_checker #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product,
  input logic               overflow
);

  // Counts cycles spent busy; compared at completion (avoids long $past)
  int unsigned busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= 0;
    else if (busy) busyCnt <= busyCnt + 1;
    else           busyCnt <= 0;
  end

  a_r3_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == WIDTH));

  a_r3_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  a_r4_not_with_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_overflow_flag: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (overflow == (product[2*WIDTH-1:WIDTH] != '0)));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  a_r8_hold_product: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(product) && $stable(overflow)));

endmodule

bind seq_shiftadd_mul seq_shiftadd_mul_checker #(.WIDTH(WIDTH)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .product  (product),
  .overflow (overflow)
);

// File: tb/tb_seq_shiftadd_mul.sv
module tb_seq_shiftadd_mul;

  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   multiplicand = '0;
  logic [W-1:0]   multiplier = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;
  logic           overflow;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  seq_shiftadd_mul #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .busy(busy), .done(done), .product(product), .overflow(overflow)
  );

  // Behavioural reference, updated on each rising edge
  bit             refBusy = 0;
  bit             refDone = 0;
  int             refLeft = 0;
  int unsigned    opA = 0, opB = 0;
  logic [2*W-1:0] refProd = '0;
  bit             refOvf = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refBusy = 0; refDone = 0; refLeft = 0; refProd = '0; refOvf = 0;
    end else begin
      refDone = 0;
      if (refBusy) begin
        refLeft = refLeft - 1;
        if (refLeft == 0) begin
          refBusy = 0;
          refDone = 1;
          refProd = (2*W)'(opA * opB);
          refOvf  = (opA * opB) >= (1 << W);
        end
      end else if (start) begin
        refBusy = 1;
        refLeft = W;
        opA = multiplicand;
        opB = multiplier;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(busy == refBusy, "R3 busy", busy, refBusy);
      check(done == refDone, "R4 done", done, refDone);
      check(product == refProd, "R5/R8 product", product, refProd);
      check(overflow == refOvf, "R6/R8 overflow", overflow, refOvf);
    end
  end

  // Launch one operation; returns at the negedge where done is high.
  // Operands are scrambled (R2) and stray starts are sent (R7) during busy.
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
    while (busy) @(negedge clk);
    start = 1'b1; multiplicand = a; multiplier = b;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (disturb) begin
        multiplicand = W'($urandom);
        multiplier   = W'($urandom);
        start        = ($urandom % 3) == 0;
      end
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic expectResult(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [2*W-1:0] e;
    e = (2*W)'(a) * (2*W)'(b);
    check(done && product == e, tag, product, e);
    check(overflow == (e[2*W-1:W] != 0), "R6 overflow", overflow, (e[2*W-1:W] != 0));
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] bset [12];
    bset = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h10, 8'h80, 8'h55, 8'hAA,
             8'h0F, 8'hF0, 8'h7F, 8'hFF};

    // R1: reset state
    #(PERIOD * 2 + 1);
    check(!busy && !done && product == 0 && !overflow, "R1 during reset", {busy, done, overflow}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && product == 0 && !overflow, "R1 after reset", product, 0);

    // R3: timing count from accepted start
    start = 1'b1; multiplicand = 8'd6; multiplier = 8'd10;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < W; i++) begin
      check(busy && !done, "R3 busy window", busy, 1);
      @(negedge clk);
    end
    check(busy, "R3 last busy cycle", busy, 1);
    @(negedge clk);
    check(!busy && done, "R3 done after WIDTH cycles", done, 1);
    expectResult(8'd6, 8'd10, "R5 six times ten");
    @(negedge clk);
    check(!done, "R4 done one cycle", done, 0);
    check(product == 16'd60, "R8 product held", product, 60);

    // R5/R6 corners
    runOp(8'hFF, 8'hFF, 0); expectResult(8'hFF, 8'hFF, "R5 all ones");
    runOp(8'h00, 8'h00, 0); expectResult(8'h00, 8'h00, "R5 zeros");
    runOp(8'h80, 8'h02, 0); expectResult(8'h80, 8'h02, "R6 carry into upper");

    // R2/R7: disturbed operands and stray starts
    runOp(8'hC3, 8'h5A, 1); expectResult(8'hC3, 8'h5A, "R2 R7 disturbed");
    runOp(8'hFE, 8'hFD, 1); expectResult(8'hFE, 8'hFD, "R2 R7 disturbed large");

    // R9 back-to-back: runOp starts at the done cycle
    runOp(8'h12, 8'h34, 0);
    check(done, "R9 prior done", done, 1);
    start = 1'b1; multiplicand = 8'h9C; multiplier = 8'hE1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R9 accepted in done cycle", busy, 1);
    while (!done) @(negedge clk);
    expectResult(8'h9C, 8'hE1, "R9 back-to-back result");

    // Every multiplicand against the pattern set
    for (int a = 0; a < (1 << W); a++) begin
      for (int k = 0; k < 12; k++) begin
        runOp(W'(a), bset[k], (k % 4) == 3);
        expectResult(W'(a), bset[k], "R5 sweep");
      end
    end

    // Random back-to-back
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom); rb = W'($urandom);
      runOp(ra, rb, n[0]);
      expectResult(ra, rb, "R5 random");
    end

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule